// File: doc/BRIEF.md
# Event Timer Register Front End

This block is the register-access side of an event timer built around one shared 32-bit up-counter and eight comparator channels. It takes single-cycle requests from a memory-mapped bus, decodes them into a capability word, a general configuration register, an interrupt status view, the main counter, and three 64-bit registers for each channel. It owns the main counter and its run/stop control. The per-channel compare logic and interrupt delivery live outside. This block reaches them through a registered write strobe with field, data and byte-lane mask, a combinational read select, and a status-clear pulse vector.

Each access is 4 or 8 bytes wide. A 4-byte access at offset +4 of a 64-bit register addresses its upper half. Writes merge into the register under a mask, and reads shift the upper half down into bits 31:0. The counter advances once on every cycle in which the tick-enable input is high and the run bit is set. Stopping the counter holds its value. Starting it again, or loading it while it runs, raises a re-arm pulse so the channels can recompute their targets.

Top module: `evt_timer_regs`

## Requirements
- R1: `acc_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. Only codes 2 and 3 are honoured. A write of any other size changes no state and raises no strobe, and a read of any other size returns zero.
- R2: An 8-byte access with `addr[2:0]` nonzero, or a 4-byte access with `addr[1:0]` nonzero, is dropped. A write has no effect and a read returns zero.
- R3: A 4-byte access with `addr[2]` set targets bits 63:32 of the register at `addr & ~7`. A write changes only that half, and a read returns that half in `rdata[31:0]` with zeros above it. A 4-byte access with `addr[2]` clear targets bits 31:0.
- R4: The capability word at offset 0x000 is read-only and contains the following fields. Bits 7:0 hold 1. Bits 12:8 hold the channel count minus one (7). Bits 15:13 are 0, and bit 13 being 0 marks a 32-bit counter. Bits 31:16 hold the fixed 16-bit vendor code 0x1D0C. Bits 63:32 hold 10^15 / 2^24, truncated, which is the tick period in femtoseconds.
- R5: The 32-bit main counter at offset 0x0F0 increments by one on each cycle where `tick_en` is high and configuration bit 0 is set, and it wraps from 0xFFFFFFFF to 0. A read returns the count zero-extended to 64 bits. The count is also driven on `count`.
- R6: The general configuration register at offset 0x010 resets to zero and stores every written bit except bit 1. Bit 0 is the run bit. Bit 1 is the legacy-routing bit, and it reads 0 after any write.
- R7: When a configuration write clears the run bit, the count holds at its value. When a write sets a previously clear run bit, counting resumes from the held value and `rearm` pulses for one cycle.
- R8: Reads at offset 0x020 return `stat_in` zero-extended. A write there pulses `stat_clr` for one cycle with exactly the bits that are both written as 1 in bits 7:0 and set in `stat_in`.
- R9: A counter write replaces the count with the current value merged with the write data under the access mask, and it takes priority over a tick in the same cycle. If the run bit is set, `rearm` pulses for one cycle. If it is clear, no pulse is raised.
- R10: A read at an offset that maps to no register returns zero, and a write there raises no strobe, no clear and no re-arm.
- R11: Channel n occupies offsets 0x100 + 0x20*n. Its configuration register sits at +0x00, its comparator at +0x08 and its message register at +0x10, with field codes 0, 1 and 2. A write there pulses bit n of `ch_wr_stb` for one cycle, with the field code, the lane-aligned data and the lane mask. A read returns `ch_rd_data`, which the channel side supplies for the index and field on `ch_rd_idx` and `ch_rd_field`.
- R12: `ack` is high in the cycle after each cycle with `req` high, and `rdata` is valid in that cycle. `rdata` is zero for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter clock enable, one tick per high cycle |
| req | input | 1 | Access request, one cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 10 | Byte offset of the access |
| acc_size | input | 2 | Access size code (see R1) |
| wdata | input | 64 | Write data, low 32 bits used for 4-byte writes |
| ack | output | 1 | Response valid, one cycle after req |
| rdata | output | 64 | Read data |
| count | output | 32 | Current main counter value |
| rearm | output | 1 | One-cycle pulse: channels recompute against the counter |
| stat_in | input | 8 | Per-channel interrupt status from the channels |
| stat_clr | output | 8 | One-cycle clear pulses to the channels |
| ch_wr_stb | output | 8 | One-hot write strobe per channel |
| ch_wr_field | output | 2 | Field code of the channel write |
| ch_wr_data | output | 64 | Lane-aligned channel write data |
| ch_wr_mask | output | 64 | Lane mask of the channel write |
| ch_rd_idx | output | 3 | Channel index decoded from addr |
| ch_rd_field | output | 2 | Field code decoded from addr |
| ch_rd_data | input | 64 | Channel register contents for the selected index and field |

## Verification
On every cycle, the assertions check that the counter only holds, steps by one or takes a loaded value. They also check that it holds while stopped, that a load lands exactly, that channel strobes are never more than one-hot, that clear pulses only touch bits that were set, and that dropped accesses cause no side effects and return zero. The bench scenarios cover the values themselves: the capability fields and the period, the merging of the two halves in each register, the wrap of the counter, the held count across a stop and restart, the re-arm pulse in its three cases, and the address map of the channels, including the unmapped fourth slot of each channel.

// File: rtl/evt_pkg.sv
package evt_pkg;

  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2,
    SZ_B8 = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_CAP,
    RG_CFG,
    RG_STAT,
    RG_CNT,
    RG_CHAN
  } reg_sel_e;

  localparam int OFS_CAP  = 'h000;
  localparam int OFS_CFG  = 'h010;
  localparam int OFS_STAT = 'h020;
  localparam int OFS_CNT  = 'h0F0;

  localparam logic [63:0] FS_PER_SEC = 64'd1000000000000000;

endpackage

// File: rtl/evt_acc_decode.sv
module evt_acc_decode
  import evt_pkg::*;
#(
  parameter int AW      = 10,
  parameter int NCH     = 8,
  parameter int CH_BASE = 'h100,
  parameter int CH_LG   = 5
) (
  input  logic [AW-1:0]          addr,
  input  logic [1:0]             size,
  input  logic [63:0]            wdata,
  output logic                   acc_ok,
  output reg_sel_e               sel,
  output logic                   upper,
  output logic [63:0]            mask,
  output logic [63:0]            data_al,
  output logic [$clog2(NCH)-1:0] ch_idx,
  output logic [1:0]             ch_field
);

  localparam int CIW    = $clog2(NCH);
  localparam int CH_END = CH_BASE + (NCH << CH_LG);
  localparam int SUBW   = CH_LG - 3;

  logic          size_ok;
  logic          align_ok;
  logic [AW-1:0] reg_ofs;
  logic [AW-1:0] ch_off;
  logic [SUBW-1:0] ch_sub;
  logic          in_ch;

  always_comb begin
    size_ok  = (size == SZ_B4) || (size == SZ_B8);
    align_ok = (size == SZ_B8) ? (addr[2:0] == 3'b000) : (addr[1:0] == 2'b00);
    acc_ok   = size_ok && align_ok;
    upper    = (size == SZ_B4) && addr[2];

    if (size == SZ_B8) begin
      mask    = '1;
      data_al = wdata;
    end else if (upper) begin
      mask    = {32'hFFFF_FFFF, 32'h0};
      data_al = {wdata[31:0], 32'h0};
    end else begin
      mask    = {32'h0, 32'hFFFF_FFFF};
      data_al = {32'h0, wdata[31:0]};
    end

    reg_ofs  = {addr[AW-1:3], 3'b000};
    ch_off   = addr - AW'(CH_BASE);
    ch_idx   = CIW'(ch_off >> CH_LG);
    ch_sub   = SUBW'(ch_off >> 3);
    ch_field = 2'(ch_sub);
    in_ch    = (32'(addr) >= 32'(CH_BASE)) && (32'(addr) < 32'(CH_END));

    if (reg_ofs == AW'(OFS_CAP))       sel = RG_CAP;
    else if (reg_ofs == AW'(OFS_CFG))  sel = RG_CFG;
    else if (reg_ofs == AW'(OFS_STAT)) sel = RG_STAT;
    else if (reg_ofs == AW'(OFS_CNT))  sel = RG_CNT;
    else if (in_ch && (32'(ch_sub) < 3)) sel = RG_CHAN;
    else                               sel = RG_NONE;
  end

endmodule

// File: rtl/evt_main_counter.sv
module evt_main_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick_en,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  output logic [CW-1:0] count
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = ld || (run && tick_en);
    cnt_d  = ld ? ld_val : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ld) |-> (count == $past(count) || count == $past(count) + CW'(1)));

  // R7
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(run) && !$past(ld)) |-> (count == $past(count)));

  // R9
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ld) |-> (count == $past(ld_val)));

endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
  import evt_pkg::*;
#(
  parameter int          AW        = 10,
  parameter int          NCH       = 8,
  parameter int          CW        = 32,
  parameter int          TICK_LG   = 24,
  parameter logic [15:0] VENDOR_ID = 16'h1D0C,
  parameter int          CH_BASE   = 'h100,
  parameter int          CH_LG     = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_en,
  input  logic                   req,
  input  logic                   we,
  input  logic [AW-1:0]          addr,
  input  logic [1:0]             acc_size,
  input  logic [63:0]            wdata,
  output logic                   ack,
  output logic [63:0]            rdata,
  output logic [CW-1:0]          count,
  output logic                   rearm,
  input  logic [NCH-1:0]         stat_in,
  output logic [NCH-1:0]         stat_clr,
  output logic [NCH-1:0]         ch_wr_stb,
  output logic [1:0]             ch_wr_field,
  output logic [63:0]            ch_wr_data,
  output logic [63:0]            ch_wr_mask,
  output logic [$clog2(NCH)-1:0] ch_rd_idx,
  output logic [1:0]             ch_rd_field,
  input  logic [63:0]            ch_rd_data
);

  localparam int          CIW       = $clog2(NCH);
  localparam logic [63:0] PERIOD_FS = FS_PER_SEC >> TICK_LG;
  localparam logic [63:0] CAP_WORD  = {PERIOD_FS[31:0], VENDOR_ID, 3'b000,
                                       5'(NCH - 1), 8'd1};

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  // access decode
  logic            acc_ok, upper;
  reg_sel_e        sel;
  logic [63:0]     mask, data_al;
  logic [CIW-1:0]  ch_idx;
  logic [1:0]      ch_field;

  evt_acc_decode #(
    .AW(AW), .NCH(NCH), .CH_BASE(CH_BASE), .CH_LG(CH_LG)
  ) u_dec (
    .addr    (addr),
    .size    (acc_size),
    .wdata   (wdata),
    .acc_ok  (acc_ok),
    .sel     (sel),
    .upper   (upper),
    .mask    (mask),
    .data_al (data_al),
    .ch_idx  (ch_idx),
    .ch_field(ch_field)
  );

  assign ch_rd_idx   = ch_idx;
  assign ch_rd_field = ch_field;

  // state
  logic [63:0]    cfg_q, cfg_d;
  logic           cfg_en;
  logic           ack_d;
  logic [63:0]    rdata_d, rd_mux;
  logic           rearm_d;
  logic [NCH-1:0] clr_d;
  logic [NCH-1:0] stb_d;
  logic           ch_en;
  logic           wr, rd;
  logic           cnt_ld;
  logic [63:0]    cnt64, cnt_merge;

  always_comb begin
    wr     = req && we && acc_ok;
    rd     = req && !we && acc_ok;
    ack_d  = req;

    cfg_en = wr && (sel == RG_CFG);
    cfg_d  = (cfg_q & ~mask) | (data_al & mask);
    cfg_d[1] = 1'b0;

    cnt64     = {{(64-CW){1'b0}}, count};
    cnt_merge = (cnt64 & ~mask) | (data_al & mask);
    cnt_ld    = wr && (sel == RG_CNT);

    rearm_d = (cfg_en && !cfg_q[0] && cfg_d[0]) || (cnt_ld && cfg_q[0]);

    clr_d = (wr && (sel == RG_STAT)) ? (data_al[NCH-1:0] & stat_in) : '0;

    ch_en = wr && (sel == RG_CHAN);
    stb_d = ch_en ? (NCH'(1) << ch_idx) : '0;

    case (sel)
      RG_CAP:  rd_mux = CAP_WORD;
      RG_CFG:  rd_mux = cfg_q;
      RG_STAT: rd_mux = {{(64-NCH){1'b0}}, stat_in};
      RG_CNT:  rd_mux = cnt64;
      RG_CHAN: rd_mux = ch_rd_data;
      default: rd_mux = '0;
    endcase
    rdata_d = rd ? (upper ? {32'h0, rd_mux[63:32]} : rd_mux) : '0;
    if (rd && (acc_size == SZ_B4) && !upper) rdata_d = {32'h0, rd_mux[31:0]};
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      cfg_q     <= '0;
      ack       <= 1'b0;
      rdata     <= '0;
      rearm     <= 1'b0;
      stat_clr  <= '0;
      ch_wr_stb <= '0;
    end else begin
      if (cfg_en) cfg_q <= cfg_d;
      ack       <= ack_d;
      rdata     <= rdata_d;
      rearm     <= rearm_d;
      stat_clr  <= clr_d;
      ch_wr_stb <= stb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      ch_wr_field <= '0;
      ch_wr_data  <= '0;
      ch_wr_mask  <= '0;
    end else if (ch_en) begin
      ch_wr_field <= ch_field;
      ch_wr_data  <= data_al;
      ch_wr_mask  <= mask;
    end
  end

  evt_main_counter #(.CW(CW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_sync),
    .run    (cfg_q[0]),
    .tick_en(tick_en),
    .ld     (cnt_ld),
    .ld_val (CW'(cnt_merge)),
    .count  (count)
  );

  // R11
  chan_onehot_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    $onehot0(ch_wr_stb));

  // R8
  stat_clr_sub_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    $past(rst_sync) |-> ((stat_clr & ~$past(stat_in)) == '0));

  // R1 R2
  bad_side_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    $past(req && !acc_ok) |->
      (ch_wr_stb == '0 && stat_clr == '0 && !rearm && rdata == '0));

endmodule

// File: tb/sim_evt_timer_regs.sv
module sim_evt_timer_regs;

  localparam logic [63:0] PER   = 64'd1000000000000000 / (64'd1 << 24);
  localparam logic [63:0] CAPX  = {PER[31:0], 16'h1D0C, 3'b000, 5'd7, 8'd1};
  localparam logic [1:0]  B1 = 2'd0, B2 = 2'd1, B4 = 2'd2, B8 = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en, req, we;
  logic [9:0]  addr;
  logic [1:0]  acc_size;
  logic [63:0] wdata;
  logic        ack, rearm;
  logic [63:0] rdata;
  logic [31:0] count;
  logic [7:0]  stat_in, stat_clr, ch_wr_stb;
  logic [1:0]  ch_wr_field, ch_rd_field;
  logic [63:0] ch_wr_data, ch_wr_mask, ch_rd_data;
  logic [2:0]  ch_rd_idx;

  always #5 clk = ~clk;

  assign ch_rd_data = {24'hC0FFEE, 5'd0, ch_rd_idx, 30'd0, ch_rd_field};

  evt_timer_regs u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .req(req), .we(we),
    .addr(addr), .acc_size(acc_size), .wdata(wdata), .ack(ack),
    .rdata(rdata), .count(count), .rearm(rearm), .stat_in(stat_in),
    .stat_clr(stat_clr), .ch_wr_stb(ch_wr_stb), .ch_wr_field(ch_wr_field),
    .ch_wr_data(ch_wr_data), .ch_wr_mask(ch_wr_mask),
    .ch_rd_idx(ch_rd_idx), .ch_rd_field(ch_rd_field), .ch_rd_data(ch_rd_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [64:0] exp_q[$];
  string       tag_q[$];

  logic        s_ack, s_rearm;
  logic [7:0]  s_stb, s_clr;
  logic [1:0]  s_field;
  logic [63:0] s_data, s_mask;

  function automatic logic [63:0] chexp(input logic [2:0] i, input logic [1:0] f);
    return {24'hC0FFEE, 5'd0, i, 30'd0, f};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected responses as the design acknowledges
  always @(negedge clk) begin
    if (rst_n && ack) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R12 unexpected ack", 64'd1, 64'd0);
      end else begin
        logic [64:0] it;
        string t;
        it = exp_q.pop_front();
        t  = tag_q.pop_front();
        if (it[64]) chk(rdata == it[63:0], t, rdata, it[63:0]);
      end
    end
  end

  task automatic acc(input bit w, input logic [9:0] a, input logic [1:0] sz,
                     input logic [63:0] wd, input logic [63:0] exp,
                     input string tag);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; acc_size = sz; wdata = wd;
    exp_q.push_back({~w, exp});
    tag_q.push_back(tag);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    s_ack = ack; s_rearm = rearm; s_stb = ch_wr_stb; s_clr = stat_clr;
    s_field = ch_wr_field; s_data = ch_wr_data; s_mask = ch_wr_mask;
    chk(s_ack == 1'b1, "R12 ack one cycle after req", 64'(s_ack), 64'd1);
  endtask

  task automatic rd(input logic [9:0] a, input logic [1:0] sz,
                    input logic [63:0] exp, input string tag);
    acc(1'b0, a, sz, 64'd0, exp, tag);
  endtask

  task automatic wr(input logic [9:0] a, input logic [1:0] sz,
                    input logic [63:0] wd, input string tag);
    acc(1'b1, a, sz, wd, 64'd0, tag);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; req = 1'b0; we = 1'b0; addr = '0;
    acc_size = B8; wdata = '0; stat_in = 8'hA5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state (R5 R6 R12)
    chk(count == 32'd0, "R5 count after reset", 64'(count), 64'd0);
    chk(ack == 1'b0 && rearm == 1'b0 && ch_wr_stb == 8'd0 && stat_clr == 8'd0,
        "R12 outputs idle after reset", 64'({ack, rearm, ch_wr_stb, stat_clr}), 64'd0);
    rd(10'h010, B8, 64'd0, "R6 config after reset");

    // capability (R4 R3)
    rd(10'h000, B8, CAPX, "R4 capability word");
    rd(10'h004, B4, {32'd0, CAPX[63:32]}, "R4 R3 period upper half");
    rd(10'h000, B4, {32'd0, CAPX[31:0]}, "R4 R3 capability lower half");
    wr(10'h000, B8, 64'hFFFF, "R4 write to capability");
    rd(10'h000, B8, CAPX, "R4 capability read-only");

    // counter load while stopped (R9 R3)
    wr(10'h0F0, B8, 64'hAAAA_BBBB_0000_0064, "R9 load stopped");
    chk(s_rearm == 1'b0, "R9 no rearm when stopped", 64'(s_rearm), 64'd0);
    rd(10'h0F0, B8, 64'h64, "R9 R5 loaded count zero-extended");
    wr(10'h0F4, B4, 64'h1234_5678, "R3 upper counter half");
    rd(10'h0F0, B8, 64'h64, "R3 upper half write leaves count");
    rd(10'h0F4, B4, 64'h0, "R5 upper half reads zero");

    // start (R6 R7)
    wr(10'h010, B8, 64'h0000_00F0_0000_0003, "R7 start");
    chk(s_rearm == 1'b1, "R7 rearm on start", 64'(s_rearm), 64'd1);
    rd(10'h010, B8, 64'h0000_00F0_0000_0001, "R6 legacy bit forced zero");

    // counting (R5)
    ticks(5);
    chk(count == 32'h69, "R5 five ticks", 64'(count), 64'h69);
    rd(10'h0F0, B8, 64'h69, "R5 read after ticks");

    // load while running, wrap (R9 R5)
    wr(10'h0F0, B4, 64'hFFFF_FFFE, "R9 load running");
    chk(s_rearm == 1'b1, "R9 rearm on running load", 64'(s_rearm), 64'd1);
    ticks(3);
    rd(10'h0F0, B8, 64'h1, "R5 wrap through zero");

    // stop and hold (R7 R3)
    wr(10'h010, B4, 64'h0, "R7 stop");
    chk(s_rearm == 1'b0, "R7 no rearm on stop", 64'(s_rearm), 64'd0);
    ticks(4);
    rd(10'h0F0, B8, 64'h1, "R7 count held while stopped");
    rd(10'h014, B4, 64'hF0, "R3 config upper half kept");
    wr(10'h010, B4, 64'h1, "R7 restart");
    chk(s_rearm == 1'b1, "R7 rearm on restart", 64'(s_rearm), 64'd1);
    ticks(2);
    rd(10'h0F0, B8, 64'h3, "R7 resume from held value");

    // status (R8)
    wr(10'h020, B8, 64'hFF0F, "R8 clear write");
    chk(s_clr == 8'h05, "R8 clear only set bits", 64'(s_clr), 64'h05);
    wr(10'h024, B4, 64'hFF, "R8 upper half clear write");
    chk(s_clr == 8'h00, "R8 R3 upper half clears nothing", 64'(s_clr), 64'h0);
    rd(10'h020, B8, 64'hA5, "R8 status read");

    // channels (R11 R3)
    wr(10'h16C, B4, 64'hDEAD_BEEF, "R11 channel 3 comparator upper");
    chk(s_stb == 8'h08 && s_field == 2'd1, "R11 strobe/field ch3",
        64'({s_stb, s_field}), 64'({8'h08, 2'd1}));
    chk(s_data == 64'hDEAD_BEEF_0000_0000 && s_mask == 64'hFFFF_FFFF_0000_0000,
        "R11 R3 lane data", s_data, 64'hDEAD_BEEF_0000_0000);
    wr(10'h1F0, B8, 64'h123, "R11 channel 7 message");
    chk(s_stb == 8'h80 && s_field == 2'd2 && s_mask == '1, "R11 strobe/field ch7",
        64'({s_stb, s_field}), 64'({8'h80, 2'd2}));
    rd(10'h1F0, B8, chexp(3'd7, 2'd2), "R11 channel 7 message read");
    rd(10'h1F4, B4, {32'd0, chexp(3'd7, 2'd2)} >> 32, "R11 R3 channel upper half");
    rd(10'h140, B8, chexp(3'd2, 2'd0), "R11 channel 2 config read");

    // unmapped (R10)
    rd(10'h118, B8, 64'h0, "R10 fourth slot of channel 0");
    rd(10'h200, B8, 64'h0, "R10 beyond channels");
    rd(10'h030, B8, 64'h0, "R10 gap offset");
    wr(10'h200, B8, 64'hFF, "R10 write beyond channels");
    chk(s_stb == 8'h0 && s_clr == 8'h0 && s_rearm == 1'b0, "R10 no side effects",
        64'({s_stb, s_clr, s_rearm}), 64'd0);

    // bad sizes (R1)
    rd(10'h000, B1, 64'h0, "R1 one-byte read");
    rd(10'h000, B2, 64'h0, "R1 two-byte read");
    wr(10'h0F0, B2, 64'h0, "R1 two-byte counter write");
    rd(10'h0F0, B8, 64'h3, "R1 counter unchanged");
    wr(10'h010, B1, 64'h0, "R1 one-byte config write");
    rd(10'h010, B4, 64'h1, "R1 config unchanged");

    // misaligned (R2)
    rd(10'h004, B8, 64'h0, "R2 misaligned 8-byte read");
    wr(10'h0F2, B4, 64'h0, "R2 misaligned counter write");
    rd(10'h0F0, B8, 64'h3, "R2 counter unchanged");
    wr(10'h16C, B8, 64'h5, "R2 misaligned channel write");
    chk(s_stb == 8'h0, "R2 no channel strobe", 64'(s_stb), 64'd0);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R12 every request acknowledged", 64'(exp_q.size()), 64'd0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule